// File: doc/BRIEF.md
# Field-Based Control/Status Register

This block is one memory-mapped register whose bits are grouped into named fields. Each bit carries its own access behaviour, chosen by a parameter. A bit can be read/write storage, a read-only status input, a sticky flag that hardware sets and software clears by writing 1, or a pulse that fires for one cycle when software writes a 1 to it. Because the behaviour is chosen per bit, status bits and writable bits sit side by side in one word. Every bit also has its own reset value.

Software sees a write strobe with write data, and a read strobe with read data. Read data is registered and is all zeros in any cycle that does not follow a read strobe, so the read buses of many such registers can be combined with a plain OR. Hardware sees one value output per bit, a status input per bit and a flag-set input per bit. A separate synchronous clear input returns the storage bits to their reset values without a core reset, for example to drop a device address when the link is reset.

The default layout packs five fields from the LSB upward, 8 bits in all, on a 16-bit data bus. `enable` at bit 0 is storage with reset value 1. `kick` at bit 1 is a pulse. `mode` at bits 5:2 is storage with reset value 4'h9. `ready` at bit 6 is status. `done` at bit 7 is a write-1-to-clear flag with reset value 0.

Top module: `fcsr_reg`

## Requirements
- R1: The access parameter gives each bit a 2-bit code: 0 for storage, 1 for status, 2 for write-1-clear flag, 3 for pulse. Bit i uses parameter bits [2i+1:2i]. After reset, storage and flag bits hold their per-bit reset values. With the default layout, `fld_q` reads 8'h25 after reset.
- R2: A storage bit takes the value of `wr_data` at its position on the clock edge after `wr_en` is sampled high. Without `wr_en` or `reg_clr`, it keeps its value.
- R3: A status bit reads back the live `sts_in` value at the edge where the read is sampled. Writes to a status bit are ignored, and its `fld_q` output is 0.
- R4: Writing 1 to a flag bit clears it on the next edge. Writing 0 to a flag bit leaves it unchanged.
- R5: A high `evt_set` at a flag position sets that flag on the next edge. If a set and a write-1 clear reach the same flag in the same cycle, the flag ends up set. `evt_set` at non-flag positions has no effect.
- R6: A pulse bit drives `fld_q` high combinationally only while `wr_en` is high and the written bit is 1; at all other times it is 0. A pulse bit reads back as 0.
- R7: `reg_clr` returns every storage bit to its reset value on the next edge. It wins over a write in the same cycle, and it leaves flag bits unchanged.
- R8: `rd_data` shows the register value on the cycle after `rd_en` is sampled high, and is 0 otherwise. Bus bits above the register width always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_clr | input | 1 | Synchronous clear of the storage bits to their reset values |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | BUS_W | Software write data |
| rd_en | input | 1 | Software read strobe |
| rd_data | output | BUS_W | Registered read data, zero when no read was strobed |
| sts_in | input | REG_W | Live hardware values for status bits |
| evt_set | input | REG_W | Hardware set requests for flag bits |
| fld_q | output | REG_W | Per-bit hardware-facing values: storage and flag contents, pulses |

## Verification
Every one of the 256 write values is applied to the default layout. Each write is followed by a readback, with the status input set to the complement of the written value. This separates storage bits, which must follow the data, from status bits, which must follow the input and never the data. It also shows the pulse bit tracking the written bit only during the strobe, and the bus bits above the register width staying at 0. Directed sequences then drive flag sets against write-0 and write-1 clears, including a set and a clear in the same cycle, to tell set priority from clear priority. They also apply the register clear alone and together with a write, to show that the clear wins and that flags are left alone.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

  localparam int unsigned MAX_BITS = 64;

  typedef enum logic [1:0] {
    ACC_RW    = 2'd0,
    ACC_RO    = 2'd1,
    ACC_W1C   = 2'd2,
    ACC_PULSE = 2'd3
  } acc_e;

  // Mask of the bits whose access code equals code.
  function automatic logic [MAX_BITS-1:0] acc_mask(
    input logic [2*MAX_BITS-1:0] acc,
    input int unsigned           nbits,
    input acc_e                  code
  );
    logic [MAX_BITS-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_BITS; i++) begin
      if (i < nbits && acc[2*i +: 2] == code) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/fcsr_rst_sync.sv
module fcsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_r;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_r[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= sync_nxt;
  end

  assign rst_sn = sync_r[STAGES-1];

endmodule

// File: rtl/fcsr_bit_cell.sv
module fcsr_bit_cell
  import fcsr_pkg::*;
#(
  parameter acc_e ACC     = ACC_RW,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic evt,
  input  logic sts,
  output logic hw_q,
  output logic rd_val
);

  generate
    if (ACC == ACC_RW) begin : g_rw
      logic q_r, q_nxt, q_en;
      always_comb begin
        q_en  = clr | wr_en;
        q_nxt = clr ? RST_VAL : wr_bit;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_r <= RST_VAL;
        else if (q_en) q_r <= q_nxt;
      end
      assign hw_q   = q_r;
      assign rd_val = q_r;
      logic unused_rw;
      assign unused_rw = ^{evt, sts};
    end else if (ACC == ACC_W1C) begin : g_w1c
      logic q_r, q_nxt, q_en;
      always_comb begin
        q_en  = evt | (wr_en & wr_bit);
        q_nxt = evt;                       // set has priority over clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_r <= RST_VAL;
        else if (q_en) q_r <= q_nxt;
      end
      assign hw_q   = q_r;
      assign rd_val = q_r;
      logic unused_w1c;
      assign unused_w1c = ^{clr, sts};
    end else if (ACC == ACC_RO) begin : g_ro
      assign hw_q   = 1'b0;
      assign rd_val = sts;
      logic unused_ro;
      assign unused_ro = ^{clk, rst_n, clr, wr_en, wr_bit, evt, RST_VAL};
    end else begin : g_pulse
      assign hw_q   = wr_en & wr_bit;
      assign rd_val = 1'b0;
      logic unused_pu;
      assign unused_pu = ^{clk, rst_n, clr, evt, sts, RST_VAL};
    end
  endgenerate

endmodule

// File: rtl/fcsr_rd_port.sv
module fcsr_rd_port #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [REG_W-1:0] rd_val,
  output logic [BUS_W-1:0] rd_data
);

  localparam int unsigned PAD_W = BUS_W - REG_W;

  logic [BUS_W-1:0] data_r;
  logic [BUS_W-1:0] data_nxt;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb data_nxt = rd_en ? {{PAD_W{1'b0}}, rd_val} : '0;
    end else begin : g_nopad
      always_comb data_nxt = rd_en ? rd_val : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_r <= '0;
    else        data_r <= data_nxt;
  end

  assign rd_data = data_r;

endmodule

// File: rtl/fcsr_reg.sv
module fcsr_reg
  import fcsr_pkg::*;
#(
  parameter int unsigned       REG_W     = 8,
  parameter int unsigned       BUS_W     = 16,
  parameter logic [2*REG_W-1:0] ACCESS   = 16'h900C,
  parameter logic [REG_W-1:0]  RST_VALUE = 8'h25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_clr,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [BUS_W-1:0] rd_data,
  input  logic [REG_W-1:0] sts_in,
  input  logic [REG_W-1:0] evt_set,
  output logic [REG_W-1:0] fld_q
);

  localparam int unsigned PAD_W = BUS_W - REG_W;

  logic             rst_sn;
  logic [REG_W-1:0] rd_val;

  fcsr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    fcsr_bit_cell #(
      .ACC     (acc_e'(ACCESS[2*i +: 2])),
      .RST_VAL (RST_VALUE[i])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_sn),
      .clr    (reg_clr),
      .wr_en  (wr_en),
      .wr_bit (wr_data[i]),
      .evt    (evt_set[i]),
      .sts    (sts_in[i]),
      .hw_q   (fld_q[i]),
      .rd_val (rd_val[i])
    );
  end

  generate
    if (PAD_W > 0) begin : g_hi
      logic unused_wd_hi;
      assign unused_wd_hi = ^wr_data[BUS_W-1:REG_W];
    end
  endgenerate

  fcsr_rd_port #(.REG_W(REG_W), .BUS_W(BUS_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sn),
    .rd_en   (rd_en),
    .rd_val  (rd_val),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/fcsr_reg_chk.sv
module fcsr_reg_chk
  import fcsr_pkg::*;
#(
  parameter int unsigned        REG_W     = 8,
  parameter int unsigned        BUS_W     = 16,
  parameter logic [2*REG_W-1:0] ACCESS    = 16'h900C,
  parameter logic [REG_W-1:0]   RST_VALUE = 8'h25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_clr,
  input logic             wr_en,
  input logic [BUS_W-1:0] wr_data,
  input logic             rd_en,
  input logic [BUS_W-1:0] rd_data,
  input logic [REG_W-1:0] evt_set,
  input logic [REG_W-1:0] fld_q
);

  localparam logic [2*MAX_BITS-1:0] ACC_X = (2*MAX_BITS)'(ACCESS);
  localparam logic [MAX_BITS-1:0] RW64 = acc_mask(ACC_X, REG_W, ACC_RW);
  localparam logic [MAX_BITS-1:0] RO64 = acc_mask(ACC_X, REG_W, ACC_RO);
  localparam logic [MAX_BITS-1:0] FL64 = acc_mask(ACC_X, REG_W, ACC_W1C);
  localparam logic [MAX_BITS-1:0] PU64 = acc_mask(ACC_X, REG_W, ACC_PULSE);
  localparam logic [REG_W-1:0] M_RW = RW64[REG_W-1:0];
  localparam logic [REG_W-1:0] M_RO = RO64[REG_W-1:0];
  localparam logic [REG_W-1:0] M_FL = FL64[REG_W-1:0];
  localparam logic [REG_W-1:0] M_PU = PU64[REG_W-1:0];
  localparam logic [BUS_W-1:0] M_RD = BUS_W'(M_RW | M_RO | M_FL);

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_clr) |=> ((fld_q & M_RW) == ($past(wr_data[REG_W-1:0]) & M_RW)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !reg_clr) |=> ((fld_q & M_RW) == ($past(fld_q) & M_RW)));

  assert_ro_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((fld_q & M_RO) == '0));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_data[REG_W-1:0] & M_FL & ~evt_set) != '0)) |=>
      ((fld_q & $past(wr_data[REG_W-1:0] & ~evt_set) & M_FL) == '0));

  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & M_FL) != '0) |=> ((fld_q & $past(evt_set) & M_FL) == ($past(evt_set) & M_FL)));

  assert_pulse_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ((fld_q & M_PU) == '0));

  assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clr |=> ((fld_q & M_RW) == (RST_VALUE & M_RW)));

  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  assert_rd_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((rd_data & ~M_RD) == '0));

endmodule

bind fcsr_reg fcsr_reg_chk #(
  .REG_W     (REG_W),
  .BUS_W     (BUS_W),
  .ACCESS    (ACCESS),
  .RST_VALUE (RST_VALUE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .reg_clr (reg_clr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .evt_set (evt_set),
  .fld_q   (fld_q)
);

// File: tb/fcsr_reg_bench.sv
`timescale 1ns/1ps
module fcsr_reg_bench;

  localparam logic [7:0] RW_M  = 8'h3D;  // bits 0,2,3,4,5
  localparam logic [7:0] RST_V = 8'h25;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_clr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        rd_en;
  logic [15:0] rd_data;
  logic [7:0]  sts_in;
  logic [7:0]  evt_set;
  logic [7:0]  fld_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] rw_m;
  logic       fl_m;

  always #5 clk = ~clk;

  fcsr_reg u_fcsr_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_clr (reg_clr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .sts_in  (sts_in),
    .evt_set (evt_set),
    .fld_q   (fld_q)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_q();
    return rw_m | {fl_m, 7'b0};
  endfunction

  // One active cycle, then idle; checks pulse during it and fld_q after it.
  task automatic step(input string tag, input logic we, input logic [15:0] wd,
                      input logic clr, input logic [7:0] ev);
    @(negedge clk);
    wr_en = we; wr_data = wd; reg_clr = clr; evt_set = ev;
    #1;
    chk("R6 pulse", {15'b0, fld_q[1]}, {15'b0, we & wd[1]});
    if (clr)     rw_m = RST_V & RW_M;
    else if (we) rw_m = wd[7:0] & RW_M;
    if (ev[7])             fl_m = 1'b1;
    else if (we && wd[7])  fl_m = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; reg_clr = 1'b0; evt_set = '0;
    #1;
    chk(tag, {8'b0, fld_q}, {8'b0, exp_q()});
  endtask

  task automatic rd(input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    chk(tag, rd_data, {8'b0, exp_q() | {1'b0, sts_in[6], 6'b0}});
    @(negedge clk);
    #1;
    chk("R8 idle read", rd_data, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_clr = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd_en = 1'b0; sts_in = 8'h40; evt_set = '0;
    rw_m = RST_V & RW_M; fl_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset fld_q", {8'b0, fld_q}, 16'h0025);
    chk("R8 reset rd_data", rd_data, 16'h0);
    rd("R1 reset readback");

    // Sweep all write values; status driven with complement.
    for (int v = 0; v < 256; v++) begin
      sts_in = ~v[7:0];
      step("R2 store", 1'b1, {8'hFF, v[7:0]}, 1'b0, 8'h00);
      rd("R3 status/R8 readback");
    end

    // Flags.
    sts_in = 8'h00;
    step("R5 set flag", 1'b0, 16'h0, 1'b0, 8'h80);
    chk("R5 flag set", {15'b0, fld_q[7]}, 16'h1);
    step("R4 write 0 keeps flag", 1'b1, 16'h0000, 1'b0, 8'h00);
    chk("R4 flag kept", {15'b0, fld_q[7]}, 16'h1);
    step("R4 write 1 clears flag", 1'b1, 16'h0080, 1'b0, 8'h00);
    chk("R4 flag cleared", {15'b0, fld_q[7]}, 16'h0);
    step("R5 set again", 1'b0, 16'h0, 1'b0, 8'h80);
    step("R5 set wins over clear", 1'b1, 16'h0080, 1'b0, 8'h80);
    chk("R5 flag after race", {15'b0, fld_q[7]}, 16'h1);
    step("R2 pre-load", 1'b1, 16'h0014, 1'b0, 8'h00);
    step("R5 evt on non-flag bits ignored", 1'b0, 16'h0, 1'b0, 8'h7F);
    chk("R5 storage untouched", {8'b0, fld_q}, 16'h0094);
    rd("R5 readback");

    // Storage clear.
    step("R2 load all", 1'b1, 16'h003C, 1'b0, 8'h00);
    step("R7 clear", 1'b0, 16'h0, 1'b1, 8'h00);
    chk("R7 flag kept", {8'b0, fld_q}, 16'h00A5);
    step("R2 load again", 1'b1, 16'h0018, 1'b0, 8'h00);
    step("R7 clear beats write", 1'b1, 16'h001A, 1'b1, 8'h00);
    chk("R7 cleared value", {8'b0, fld_q}, 16'h00A5);
    sts_in = 8'h40;
    rd("R7 readback");
    sts_in = 8'h00;
    rd("R3 live status change");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule